// File: doc/BRIEF.md
# GPIO Pad Controller with Interrupt Detection

This block is a memory-mapped controller for a parameterizable set of general-purpose pads. Each pad owns a 16-byte register window. The window holds a trigger and mode configuration word, a general 32-bit configuration word and a small value word. The value word carries the active-low input and output enables and the pad level. Software reaches the registers over a simple synchronous 32-bit bus with byte addresses. Read data is returned one cycle after the request.

Toward the pads the block drives an output level, an output enable and an open-drain flag for each pad. It takes a raw input level for each pad and resynchronizes it internally. For every pad it detects rising edges, falling edges, both edges, or active-high or active-low levels. A detected event is latched into a status bit. Status bits are packed 32 pads to a word in a separate status area and are cleared by writing ones. One interrupt output is raised whenever any status bit is set.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every configuration word 0 reads 0 and every value word reads 0x6 (input and output disabled, level 0). All `pad_oe`, all `pad_od`, all status bits and `irq` are 0.
- R2: Pad p's configuration word 0 is at byte address p*16, configuration word 1 at p*16+4 and the value word at p*16+8. Read data appears on `bus_rdata` in the cycle after the read request. Configuration word 1 stores all 32 bits. Configuration word 0 stores bits 31, 27:24 and 10:0 (mask 0x8F0007FF); its other bits read 0.
- R3: Value word bit 2 is input enable and bit 1 is output enable, both active low. Bit 0 reads the synchronized pad input when bit 2 is 0 and reads 0 when bit 2 is 1. Writing bit 0 sets the level the pad drives.
- R4: When configuration word 0 bit 31 (open drain) is 0, `pad_out` equals the written level and `pad_oe` is the inverse of value bit 1.
- R5: When configuration word 0 bit 31 is 1, `pad_od` is 1, `pad_out` is 0 and `pad_oe` is 1 exactly while the written level is 0.
- R6: With configuration word 0 bit 24 clear, bit 25 alone latches status on a rising input and bit 26 alone latches on a falling input. Bits 25 and 26 together latch on either edge. With bits 24 to 26 all clear, no status is latched.
- R7: With bit 24 set, bit 25 latches status while the input is high and bit 26 latches while it is low. The status bit cannot be cleared while the active level persists.
- R8: A pad latches no status unless its function field (configuration word 0 bits 2:0) equals the `GPIO_FUNC` parameter (default 0) and its direct-interrupt bit 27 is 0.
- R9: Status for pad n is bit n%32 of the word at byte address 0x800 + 4*(n/32). Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged.
- R10: `irq` is 1 whenever any status bit is set and 0 when all are clear.
- R11: Reads of unmapped addresses return 0. Unmapped addresses are offset 0xC within a pad window, windows of pads at or above `NUM_PADS`, and status words beyond the last implemented one.
- R12: When a clear of a status bit and a new trigger for that pad fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Driven pad levels |
| pad_oe | output | NUM_PADS | Pad output enables, active high |
| pad_od | output | NUM_PADS | Open-drain mode flags |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every trigger encoding against every start and end input level. It checks each result against a model that accounts for level modes latching on the level held before the transition. A design that treats the level mode as an edge mode, or that ignores the polarity bits, would miss those events. Eligibility is checked by placing the function field and the direct-interrupt bit at random. A controller that skipped this gating would raise spurious status. The bench also covers a pad in the second status word, a clear attempted while an active level persists, and a write of zeros to the status area. A wrong word index, a plain store in place of clear-on-one, or a clear that wins over a live trigger would each show up as a wrong status read or a wrong `irq` level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PIDX_W = 7;

  // configuration word 0 bit positions
  localparam int C0_OPEN_DRAIN = 31;
  localparam int C0_DIRECT     = 27;
  localparam int C0_FALL       = 26;
  localparam int C0_RISE       = 25;
  localparam int C0_LEVEL      = 24;
  localparam logic [31:0] C0_KEEP = 32'h8F00_07FF;

  // value word bit positions
  localparam int V_IN_DIS  = 2;
  localparam int V_OUT_DIS = 1;
  localparam int V_LVL     = 0;

  typedef enum logic [1:0] {
    SLOT_CFG0 = 2'd0,
    SLOT_CFG1 = 2'd1,
    SLOT_VAL  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  // trigger decision for one pad from its mode bits and two samples
  function automatic logic trig_fire(input logic lvl_mode, input logic rise_en,
                                     input logic fall_en, input logic cur,
                                     input logic prev);
    logic fired;
    if (lvl_mode)
      fired = (rise_en & cur) | (fall_en & ~cur);
    else
      fired = (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
    return fired;
  endfunction

  // pad output enable from mode and value bits
  function automatic logic drive_enable(input logic od, input logic lvl,
                                        input logic out_dis);
    return od ? ~lvl : ~out_dis;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  input  logic [N-1:0] lvl_mode,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] elig,
  output logic [N-1:0] hit
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar p = 0; p < N; p++) begin : g_pad
    assign hit[p] = elig[p] &
                    trig_fire(lvl_mode[p], rise_en[p], fall_en[p], level[p], prev_q[p]);
  end
endmodule

// File: rtl/gpio_int_status.sv
module gpio_int_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] stat_q;
  logic         irq_q;

  // a trigger in the clear cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | hit;
    end
  end

  always_comb irq_q = |stat_q;

  assign status = stat_q;
  assign irq    = irq_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PADS  = 40,
  parameter int GPIO_FUNC = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_od,
  output logic                irq
);
  localparam int NWORDS = (NUM_PADS + 31) / 32;
  localparam int SPAD_W = NWORDS * 32;
  localparam logic [2:0] FUNC_CODE = 3'(GPIO_FUNC);

  // decode
  logic             wr_en, rd_en;
  logic [PIDX_W-1:0] pad_sel;
  logic [8:0]       word_sel;
  slot_e            slot;
  logic             pad_space, stat_space;
  logic             unused_addr;

  assign wr_en      = bus_valid & bus_write;
  assign rd_en      = bus_valid & ~bus_write;
  assign pad_sel    = bus_addr[10:4];
  assign slot       = slot_e'(bus_addr[3:2]);
  assign word_sel   = bus_addr[10:2];
  assign pad_space  = ~bus_addr[11] & (int'(pad_sel) < NUM_PADS);
  assign stat_space = bus_addr[11] & (int'(word_sel) < NWORDS);
  assign unused_addr = ^bus_addr[1:0];

  // per-pad storage
  logic [31:0] cfg0_q [NUM_PADS];
  logic [31:0] cfg1_q [NUM_PADS];
  logic [NUM_PADS-1:0] in_dis_q, out_dis_q, lvl_q;

  logic [NUM_PADS-1:0] sync_in, eff_in;
  logic [NUM_PADS-1:0] mode_lvl, mode_rise, mode_fall, pad_elig;
  logic [NUM_PADS-1:0] trig_hit, stat_clr, stat_q;
  logic [SPAD_W-1:0]   stat_wide;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic sel;
    assign sel = wr_en & pad_space & (pad_sel == PIDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg0_q[p]    <= '0;
        cfg1_q[p]    <= '0;
        in_dis_q[p]  <= 1'b1;
        out_dis_q[p] <= 1'b1;
        lvl_q[p]     <= 1'b0;
      end else if (sel) begin
        case (slot)
          SLOT_CFG0: cfg0_q[p] <= bus_wdata & C0_KEEP;
          SLOT_CFG1: cfg1_q[p] <= bus_wdata;
          SLOT_VAL: begin
            in_dis_q[p]  <= bus_wdata[V_IN_DIS];
            out_dis_q[p] <= bus_wdata[V_OUT_DIS];
            lvl_q[p]     <= bus_wdata[V_LVL];
          end
          default: ;
        endcase
      end
    end

    assign eff_in[p]    = sync_in[p] & ~in_dis_q[p];
    assign mode_lvl[p]  = cfg0_q[p][C0_LEVEL];
    assign mode_rise[p] = cfg0_q[p][C0_RISE];
    assign mode_fall[p] = cfg0_q[p][C0_FALL];
    assign pad_elig[p]  = (cfg0_q[p][2:0] == FUNC_CODE) & ~cfg0_q[p][C0_DIRECT];

    assign pad_od[p]  = cfg0_q[p][C0_OPEN_DRAIN];
    assign pad_out[p] = cfg0_q[p][C0_OPEN_DRAIN] ? 1'b0 : lvl_q[p];
    assign pad_oe[p]  = drive_enable(cfg0_q[p][C0_OPEN_DRAIN], lvl_q[p], out_dis_q[p]);

    assign stat_clr[p] = wr_en & stat_space & (word_sel == 9'(p / 32)) &
                         bus_wdata[p % 32];
  end

  gpio_in_sync #(.W(NUM_PADS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (sync_in)
  );

  gpio_trig_detect #(.N(NUM_PADS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (eff_in),
    .lvl_mode(mode_lvl),
    .rise_en (mode_rise),
    .fall_en (mode_fall),
    .elig    (pad_elig),
    .hit     (trig_hit)
  );

  gpio_int_status #(.N(NUM_PADS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (trig_hit),
    .clr_mask(stat_clr),
    .status  (stat_q),
    .irq     (irq)
  );

  assign stat_wide = SPAD_W'(stat_q);

  // read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (pad_space && pad_sel == PIDX_W'(p)) begin
        case (slot)
          SLOT_CFG0: rd_mux = cfg0_q[p];
          SLOT_CFG1: rd_mux = cfg1_q[p];
          SLOT_VAL:  rd_mux = {29'b0, in_dis_q[p], out_dis_q[p], eff_in[p]};
          default:   rd_mux = '0;
        endcase
      end
    end
    for (int w = 0; w < NWORDS; w++) begin
      if (stat_space && word_sel == 9'(w)) rd_mux = stat_wide[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hit,
  input logic [N-1:0] elig,
  input logic [N-1:0] clr_mask,
  input logic [N-1:0] status,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_od,
  input logic         irq
);
  // R8: detector output stays quiet on ineligible pads
  a_r8_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~elig) == '0);

  // R6 / R12: every trigger is latched on the next edge, clear or not
  a_r12_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(hit)) == $past(hit)));

  // R9: a clear with no trigger empties the bit
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_mask & ~hit)) == '0));

  // R9: no bit sets without a trigger
  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));

  // R10: interrupt only rises after a trigger
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|hit));

  // R5: open-drain pads never drive high
  a_r5_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_out) == '0);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.N(NUM_PADS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hit     (trig_hit),
  .elig    (pad_elig),
  .clr_mask(stat_clr),
  .status  (stat_q),
  .pad_out (pad_out),
  .pad_od  (pad_od),
  .irq     (irq)
);

// File: tb/tb_gpio_pad_ctrl.sv
module tb_gpio_pad_ctrl;
  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_od;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_pad_ctrl #(.NUM_PADS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pad_a(int p, int off);
    return 12'(p * 16 + off);
  endfunction

  function automatic logic [11:0] stat_a(int p);
    return 12'(12'h800 + 4 * (p / 32));
  endfunction

  // expected status after config held at start level, then moved to end level
  function automatic bit exp_stat(logic [31:0] c, bit s, bit e);
    if (c[2:0] != 3'd0 || c[27]) return 1'b0;
    if (c[24]) return (c[25] && (s || e)) || (c[26] && (!s || !e));
    return (c[25] && !s && e) || (c[26] && s && !e);
  endfunction

  task automatic trig_case(int p, logic [31:0] c, bit s, bit e);
    logic [31:0] d;
    wr(pad_a(p, 0), 32'h0);
    wr(pad_a(p, 8), 32'h2);
    pad_in[p] = s;
    idle(4);
    wr(stat_a(p), 32'hFFFF_FFFF);
    wr(pad_a(p, 0), c);
    idle(4);
    pad_in[p] = e;
    idle(5);
    rd(stat_a(p), d);
    chk($sformatf("R6/R7/R8 pad%0d cfg=%h %0d->%0d", p, c, s, e),
        32'(d[p % 32]), 32'(exp_stat(c, s, e)));
    wr(pad_a(p, 0), 32'h0);
    wr(stat_a(p), 32'hFFFF_FFFF);
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(pad_a(3, 0), d);  chk("R1 cfg0 reset", d, 32'h0);
    rd(pad_a(3, 8), d);  chk("R1 val reset", d, 32'h6);
    chk("R1 pad_oe reset", 32'(pad_oe != 0), 32'h0);
    chk("R1 pad_od reset", 32'(pad_od != 0), 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);
    rd(12'h800, d); chk("R1 status reset", d, 32'h0);

    // R2 random register readback
    for (int i = 0; i < 30; i++) begin
      int p = $urandom_range(NP - 1);
      logic [31:0] v0 = $urandom();
      logic [31:0] v1 = $urandom();
      wr(pad_a(p, 4), v1);
      wr(pad_a(p, 0), v0);
      rd(pad_a(p, 4), d); chk("R2 cfg1 readback", d, v1);
      rd(pad_a(p, 0), d); chk("R2 cfg0 masked readback", d, v0 & 32'h8F00_07FF);
      wr(pad_a(p, 0), 32'h0);
    end
    for (int w = 0; w < 2; w++) wr(12'(12'h800 + 4 * w), 32'hFFFF_FFFF);
    idle(2);

    // R3 value word
    pad_in[5] = 1'b1;
    wr(pad_a(5, 8), 32'h0);
    idle(3);
    rd(pad_a(5, 8), d); chk("R3 level reads input", d, 32'h1);
    wr(pad_a(5, 8), 32'h4);
    idle(3);
    rd(pad_a(5, 8), d); chk("R3 input disabled reads 0", d, 32'h4);
    pad_in[5] = 1'b0;

    // R4 push-pull drive
    wr(pad_a(6, 8), 32'h1);
    chk("R4 pad_out follows level", 32'(pad_out[6]), 32'h1);
    chk("R4 pad_oe on", 32'(pad_oe[6]), 32'h1);
    wr(pad_a(6, 8), 32'h2);
    chk("R4 pad_oe off", 32'(pad_oe[6]), 32'h0);

    // R5 open drain
    wr(pad_a(6, 0), 32'h8000_0000);
    wr(pad_a(6, 8), 32'h3);
    chk("R5 pad_od", 32'(pad_od[6]), 32'h1);
    chk("R5 released when level 1", {pad_oe[6], pad_out[6]}, 32'h0);
    wr(pad_a(6, 8), 32'h2);
    chk("R5 pulls low when level 0", {pad_oe[6], pad_out[6]}, 32'h2);
    wr(pad_a(6, 0), 32'h0);

    // R6 R7 R8 exhaustive trigger modes on two pads in different words
    for (int m = 0; m < 8; m++)
      for (int se = 0; se < 4; se++) begin
        trig_case(9, 32'(m) << 24, se[1], se[0]);
        trig_case(35, 32'(m) << 24, se[1], se[0]);
      end
    // R8 random eligibility
    for (int i = 0; i < 40; i++) begin
      int p = $urandom_range(NP - 1);
      logic [31:0] c = (32'($urandom_range(7)) << 24) |
                       (($urandom_range(3) == 0) ? 32'h0800_0000 : 32'h0) |
                       (($urandom_range(2) == 0) ? 32'($urandom_range(7)) : 32'h0);
      trig_case(p, c, 1'($urandom_range(1)), 1'($urandom_range(1)));
    end

    // R9 R10 R12 clear behaviour
    wr(pad_a(34, 8), 32'h2);
    pad_in[34] = 1'b0;
    idle(4);
    wr(pad_a(34, 0), 32'h0200_0000);
    pad_in[34] = 1'b1;
    idle(5);
    rd(12'h804, d); chk("R9 pad34 word1 bit2", d, 32'h4);
    chk("R10 irq set", 32'(irq), 32'h1);
    wr(12'h804, 32'h0);
    rd(12'h804, d); chk("R9 zero write keeps", d, 32'h4);
    wr(12'h804, 32'h4);
    rd(12'h804, d); chk("R9 clear", d, 32'h0);
    chk("R10 irq clear", 32'(irq), 32'h0);
    wr(pad_a(34, 0), 32'h0300_0000);
    idle(3);
    wr(12'h804, 32'hFFFF_FFFF);
    rd(12'h804, d); chk("R7 R12 level persists over clear", d, 32'h4);
    pad_in[34] = 1'b0;
    idle(4);
    wr(12'h804, 32'hFFFF_FFFF);
    rd(12'h804, d); chk("R7 level gone clears", d, 32'h0);
    wr(pad_a(34, 0), 32'h0);

    // R11 unmapped
    rd(pad_a(2, 12), d);  chk("R11 slot 0xC", d, 32'h0);
    rd(pad_a(NP, 0), d);  chk("R11 pad beyond range", d, 32'h0);
    rd(12'h808, d);       chk("R11 status beyond words", d, 32'h0);
    rd(12'hFFC, d);       chk("R11 top address", d, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule